// File: doc/BRIEF.md
# Quadword Packing DMA Write Bridge

This block sits between a narrow DMA stream and a wide memory write port. Beats of 32 bits arrive with a valid/ready handshake and a last marker. The block gathers four of them into one 128-bit quadword and hands that quadword to the memory side as a single write. The write carries an address, the data, a 16-bit byte-enable mask and a one-cycle write strobe. Addresses start at a base value set by a parameter and advance by one quadword per write.

A transfer does not have to be a multiple of four beats. When the last beat closes a group early, the block still writes the group. The byte enables then cover only the lanes that arrived, and the lanes that did not arrive are zero in the data. The block holds its input ready low in each cycle that it drives a write. A completion flag rises with the write that carries the last beat of a transfer and stays high until reset, so handshake logic further on can wait on it.

Top module: `dma_qw_pack_bridge`

## Requirements
- R1: Within a quadword, beat k of the group (k = 0..3, in order of acceptance) occupies `wr_data[32k+31:32k]`, so the first beat sits in bits [31:0] and the fourth in bits [127:96].
- R2: Exactly one write (`wr_en` high for one cycle) is issued per closed group, in the cycle right after the clock edge that accepts the closing beat. A group closes on its fourth beat or on a beat that has `in_last` high.
- R3: `in_ready` is low in exactly those cycles in which `wr_en` is high, and high in all other cycles after reset.
- R4: A group closed by `in_last` after N beats (N = 1, 2 or 3) is written with `wr_be` equal to the 4N lowest bits set: 0x000F, 0x00FF or 0x0FFF.
- R5: `done` is low from reset until the write that carries a last beat. It is high in that write's cycle and in every cycle after it, until reset.
- R6: The first write after reset goes to `BASE_ADDR`. Each later write goes 16 bytes above the previous one, also across transfer boundaries. `wr_addr` does not change in cycles without a write.
- R7: A group of four beats is written with `wr_be` = 0xFFFF.
- R8: In a partial group, the data lanes without a byte enable are zero.
- R9: The beat that follows a last beat goes into lane 0 of a new quadword.
- R10: Synchronous active-high `rst` leaves `in_ready` = 1, `wr_en` = 0, `done` = 0 and `wr_addr` = `BASE_ADDR`, and it drops any partly gathered group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A beat is offered |
| in_ready | output | 1 | The bridge can take a beat this cycle |
| in_data | input | BEAT_W (32) | Beat payload |
| in_last | input | 1 | This beat ends the transfer |
| wr_en | output | 1 | Write strobe to the memory side |
| wr_addr | output | ADDR_W (32) | Byte address of the quadword being written |
| wr_data | output | BEAT_W*LANES (128) | Packed quadword |
| wr_be | output | BEAT_W*LANES/8 (16) | Byte enables, bit i for byte i of `wr_data` |
| done | output | 1 | Sticky flag: a transfer's last beat has been written |

## Verification
The bench builds the block with 32-bit beats, four lanes, 32-bit addresses and a base address of 0x1F00, the shipped shape with a non-zero base. With only four lanes, a sweep of transfer lengths 1 to 9 covers every remainder class. Those are full groups alone, full groups followed by one, two or three trailing beats, and a single short group. The sweep is repeated with zero, one and two idle cycles between beats, so beats arrive both back to back and spaced out against the emit stall. A reset in the middle of the run then shows that the address returns to the base and that the completion flag clears.

// File: rtl/qwb_pkg.sv
package qwb_pkg;

    typedef enum logic {
        PH_GATHER = 1'b0,
        PH_EMIT   = 1'b1
    } phase_e;

    localparam int unsigned BITS_PER_BYTE = 8;

    function automatic int unsigned bytes_in(input int unsigned bits);
        return bits / BITS_PER_BYTE;
    endfunction

endpackage

// File: rtl/qwb_lane_packer.sv
module qwb_lane_packer #(
    parameter int unsigned BEAT_W = 32,
    parameter int unsigned LANES  = 4,
    localparam int unsigned IDX_W  = $clog2(LANES),
    localparam int unsigned CNT_W  = $clog2(LANES + 1),
    localparam int unsigned WORD_W = BEAT_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              last,
    input  logic [BEAT_W-1:0] beat,
    output logic              close,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  fill
);

    logic [IDX_W-1:0] idx_q;

    // a group closes on its top lane or on a last marker
    assign close = take && (last || (idx_q == IDX_W'(LANES - 1)));
    assign fill  = CNT_W'(idx_q) + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || close) begin
            idx_q <= '0;
        end else if (take) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // lanes are cleared after each close, so unwritten lanes read as zero
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BEAT_W-1:0] hold_q;
        logic              hit;

        assign hit = take && (idx_q == IDX_W'(l));

        always_ff @(posedge clk) begin
            if (rst || close) begin
                hold_q <= '0;
            end else if (hit) begin
                hold_q <= beat;
            end
        end

        assign word[l*BEAT_W +: BEAT_W] = hit ? beat : hold_q;
    end

endmodule

// File: rtl/qwb_emit_stage.sv
module qwb_emit_stage
    import qwb_pkg::*;
#(
    parameter int unsigned WORD_W = 128,
    parameter int unsigned LANES  = 4,
    parameter int unsigned CNT_W  = 3,
    localparam int unsigned BE_W       = bytes_in(WORD_W),
    localparam int unsigned LANE_BYTES = BE_W / LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              close,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  fill,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic [BE_W-1:0]   wr_be
);

    phase_e            phase_q;
    logic [BE_W-1:0]   be_next;
    logic [WORD_W-1:0] data_q;
    logic [BE_W-1:0]   be_q;

    for (genvar l = 0; l < LANES; l++) begin : g_be
        assign be_next[l*LANE_BYTES +: LANE_BYTES] =
            (fill > CNT_W'(l)) ? {LANE_BYTES{1'b1}} : {LANE_BYTES{1'b0}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_GATHER;
        end else begin
            phase_q <= close ? PH_EMIT : PH_GATHER;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            be_q   <= '0;
        end else if (close) begin
            data_q <= word;
            be_q   <= be_next;
        end
    end

    assign wr_en   = (phase_q == PH_EMIT);
    assign wr_data = data_q;
    assign wr_be   = be_q;

endmodule

// File: rtl/qwb_addr_stepper.sv
module qwb_addr_stepper #(
    parameter int unsigned      ADDR_W    = 32,
    parameter int unsigned      STEP      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= BASE_ADDR;
        end else if (advance) begin
            addr_q <= addr_q + ADDR_W'(STEP);
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/qwb_sticky_flag.sv
module qwb_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    output logic flag
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/dma_qw_pack_bridge.sv
module dma_qw_pack_bridge
    import qwb_pkg::*;
#(
    parameter int unsigned       BEAT_W    = 32,
    parameter int unsigned       LANES     = 4,
    parameter int unsigned       ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   in_valid,
    output logic                                   in_ready,
    input  logic [BEAT_W-1:0]                      in_data,
    input  logic                                   in_last,
    output logic                                   wr_en,
    output logic [ADDR_W-1:0]                      wr_addr,
    output logic [BEAT_W*LANES-1:0]                wr_data,
    output logic [(BEAT_W*LANES)/BITS_PER_BYTE-1:0] wr_be,
    output logic                                   done
);

    localparam int unsigned WORD_W = BEAT_W * LANES;
    localparam int unsigned BE_W   = bytes_in(WORD_W);
    localparam int unsigned CNT_W  = $clog2(LANES + 1);

    logic              take;
    logic              close;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  fill;
    logic              emit;

    // the input stalls only while a quadword is on the write port
    assign in_ready = !emit;
    assign take     = in_valid && in_ready;

    qwb_lane_packer #(
        .BEAT_W (BEAT_W),
        .LANES  (LANES)
    ) u_pack (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .last  (in_last),
        .beat  (in_data),
        .close (close),
        .word  (word),
        .fill  (fill)
    );

    qwb_emit_stage #(
        .WORD_W (WORD_W),
        .LANES  (LANES),
        .CNT_W  (CNT_W)
    ) u_emit (
        .clk     (clk),
        .rst     (rst),
        .close   (close),
        .word    (word),
        .fill    (fill),
        .wr_en   (emit),
        .wr_data (wr_data),
        .wr_be   (wr_be)
    );

    qwb_addr_stepper #(
        .ADDR_W    (ADDR_W),
        .STEP      (BE_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .advance (emit),
        .addr    (wr_addr)
    );

    qwb_sticky_flag u_done (
        .clk  (clk),
        .rst  (rst),
        .set  (close && in_last),
        .flag (done)
    );

    assign wr_en = emit;

endmodule

// File: rtl/qwb_bridge_checker.sv
module qwb_bridge_checker #(
    parameter int unsigned BEAT_W = 32,
    parameter int unsigned LANES  = 4,
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned WORD_W     = BEAT_W * LANES,
    localparam int unsigned BE_W       = WORD_W / 8,
    localparam int unsigned LANE_BYTES = BE_W / LANES
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic [BE_W-1:0]   wr_be,
    input logic              done
);

    logic [WORD_W-1:0] be_bits;

    for (genvar b = 0; b < BE_W; b++) begin : g_bits
        assign be_bits[b*8 +: 8] = {8{wr_be[b]}};
    end

    p_ready_gap_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !in_ready);

    p_ready_open_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> in_ready);

    p_one_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (wr_addr == $past(wr_addr) + ADDR_W'(BE_W)));

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(wr_addr));

    p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_done_with_write_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> wr_en);

    // R4 / R7: enables form a nonempty low prefix of whole lanes
    p_be_prefix_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_be != '0) && ((wr_be & (wr_be + 1'b1)) == '0)
                   && (($countones(wr_be) % LANE_BYTES) == 0)));

    p_pad_zero_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_data & ~be_bits) == '0));

endmodule

bind dma_qw_pack_bridge qwb_bridge_checker #(
    .BEAT_W (BEAT_W),
    .LANES  (LANES),
    .ADDR_W (ADDR_W)
) u_qwb_chk (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .done     (done)
);

// File: tb/sim_dma_qw_pack_bridge.sv
`timescale 1ns/1ps
module sim_dma_qw_pack_bridge;

    localparam int unsigned BEAT_W = 32;
    localparam int unsigned LANES  = 4;
    localparam int unsigned ADDR_W = 32;
    localparam logic [31:0] BASE   = 32'h0000_1F00;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_data = '0;
    logic         in_last = 1'b0;
    logic         wr_en;
    logic [31:0]  wr_addr;
    logic [127:0] wr_data;
    logic [15:0]  wr_be;
    logic         done;

    always #2 clk = ~clk;

    dma_qw_pack_bridge #(
        .BEAT_W    (BEAT_W),
        .LANES     (LANES),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE)
    ) u0 (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .in_last  (in_last),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_be    (wr_be),
        .done     (done)
    );

    int           n_checks = 0;
    int           n_fail   = 0;
    logic [127:0] exp_data [0:255];
    logic [15:0]  exp_be   [0:255];
    logic [31:0]  exp_addr [0:255];
    int           n_exp  = 0;
    int           n_seen = 0;
    logic [31:0]  model_addr = BASE;
    logic [127:0] cur = '0;
    int           cur_n = 0;
    bit           mon_on = 1'b0;
    bit           seen_last = 1'b0;

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write-port monitor, away from the active edge
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (wr_en) begin
                if (n_seen < n_exp) begin
                    check(wr_data == exp_data[n_seen], "R1/R8 data", wr_data, exp_data[n_seen]);
                    check(wr_be == exp_be[n_seen], "R4/R7 byte enables",
                          128'(wr_be), 128'(exp_be[n_seen]));
                    check(wr_addr == exp_addr[n_seen], "R6 address",
                          128'(wr_addr), 128'(exp_addr[n_seen]));
                end else begin
                    check(1'b0, "R2 unexpected write", 128'(n_seen), 128'(n_exp));
                end
                n_seen++;
            end
            check(in_ready == !wr_en, "R3 ready vs write", 128'(in_ready), 128'(!wr_en));
        end
    end

    task automatic send_beat(input logic [31:0] val, input bit last, input int gap);
        repeat (gap) @(negedge clk);
        forever begin
            @(negedge clk);
            if (!seen_last)
                check(done == 1'b0, "R5 low before any last", 128'(done), 128'(0));
            in_valid = 1'b1;
            in_data  = val;
            in_last  = last;
            if (in_ready) break;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
        // arithmetic model: R9 lane restart after last, R6 address run
        cur[cur_n*32 +: 32] = val;
        cur_n++;
        if (cur_n == 4 || last) begin
            exp_data[n_exp] = cur;
            exp_be[n_exp]   = (cur_n == 4) ? 16'hFFFF : 16'((1 << (4 * cur_n)) - 1);
            exp_addr[n_exp] = model_addr;
            n_exp++;
            model_addr = model_addr + 32'd16;
            cur   = '0;
            cur_n = 0;
            @(negedge clk);
            check(wr_en == 1'b1, "R2 write follows closing beat", 128'(wr_en), 128'(1));
            if (last) begin
                seen_last = 1'b1;
                check(done == 1'b1, "R5 done with last write", 128'(done), 128'(1));
            end
        end
    endtask

    task automatic send_xfer(input int tag, input int len, input int gap);
        for (int i = 0; i < len; i++) begin
            send_beat({8'(tag), 8'(i), 16'hC3A5 ^ 16'(tag * 37 + i)}, (i == len - 1), gap);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        check(1'b0, "watchdog expired", 128'(0), 128'(1));
        finish_run();
    end

    initial begin
        int tag = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check(in_ready == 1'b1, "R10 ready after reset", 128'(in_ready), 128'(1));
        check(wr_en == 1'b0, "R10 no write after reset", 128'(wr_en), 128'(0));
        check(done == 1'b0, "R10 done clear", 128'(done), 128'(0));
        check(wr_addr == BASE, "R10 address at base", 128'(wr_addr), 128'(BASE));
        mon_on = 1'b1;

        for (int gap = 0; gap < 3; gap++) begin
            for (int len = 1; len <= 9; len++) begin
                send_xfer(tag, len, gap);
                tag++;
            end
        end
        repeat (3) @(negedge clk);
        check(n_seen == n_exp, "R2 write count", 128'(n_seen), 128'(n_exp));
        check(done == 1'b1, "R5 done stays high", 128'(done), 128'(1));

        // reset in the middle of a group: partial data must be dropped
        send_beat(32'hDEAD_0001, 1'b0, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cur = '0;
        cur_n = 0;
        model_addr = BASE;
        seen_last = 1'b0;
        check(done == 1'b0, "R10 done cleared by reset", 128'(done), 128'(0));
        check(wr_addr == BASE, "R10 address back to base", 128'(wr_addr), 128'(BASE));
        check(in_ready == 1'b1, "R10 ready after reset", 128'(in_ready), 128'(1));
        send_xfer(200, 6, 0);
        repeat (3) @(negedge clk);
        check(n_seen == n_exp, "R2 write count after reset", 128'(n_seen), 128'(n_exp));
        finish_run();
    end

endmodule